// File: doc/BRIEF.md
# Flash Block Erase-Verify Sequencer

This block runs the erase of one on-chip flash block and then proves that the block really is blank. Software writes a block-select mask and pulses a start input. If exactly one mask bit is set, the sequencer does the following:

- It raises an erase-enable line toward the flash for a fixed number of clock cycles.
- It makes a dummy write of the byte 0xFF to the first word of the selected block.
- It reads the block back one 32-bit word per cycle.

If any word reads other than all ones, the block is erased again and scanned again, up to a bounded number of attempts. A cycle-count watchdog stops an erase pulse that has lasted too long. An interrupt-block output stays high for the whole operation.

The state machine has five states:

- **S_IDLE**: waiting for a start.
- **S_ERASE**: the erase pulse is active.
- **S_DUMMY**: the one-cycle dummy write.
- **S_VERIFY**: the word-by-word scan.
- **S_FINISH**: a one-cycle completion state.

Its transitions are:

- **T_ACCEPT**: S_IDLE to S_ERASE, on a start with a one-hot mask.
- **T_REJECT**: S_IDLE to S_IDLE, on a start with a bad mask. The select-error flag is raised.
- **T_PULSE_END**: S_ERASE to S_DUMMY.
- **T_WD_TRIP**: S_ERASE to S_FINISH, with a fail result.
- **T_SCAN**: S_DUMMY to S_VERIFY.
- **T_REERASE**: S_VERIFY to S_ERASE, on a mismatch while attempts remain.
- **T_GIVE_UP**: S_VERIFY to S_FINISH, on a mismatch during the last allowed attempt.
- **T_CLEAN**: S_VERIFY to S_FINISH, when the last word matches.
- **T_RETURN**: S_FINISH to S_IDLE.

Flash reads are combinational: data asked for with the read strobe is returned on `fl_rdata_i` in the same cycle. Block sizes come from a packed parameter that holds one word count per block. The blocks lie back to back in index order starting at byte address 0, so block b starts at four times the sum of the word counts of blocks 0 to b-1.

Top module: `blk_erase_seq`

## Requirements
- R1: A start with a mask that has zero bits set, or more than one bit set, is refused. In that case `sel_err_o` is high for exactly the one cycle after the start, `busy_o` stays low, and no erase, write or read strobe appears.
- R2: During any erase pulse, `ers_blk_o` has exactly one bit set: the mask bit captured at the accepted start. A start issued while busy changes nothing.
- R3: No write reaches the flash before the first erase pulse of a run. The first flash action after an accepted start is the erase enable, in the cycle after the start.
- R4: Each erase attempt holds `ers_en_o` high for exactly ERASE_CYC consecutive cycles, when ERASE_CYC < WDOG_CYC.
- R5: If `ers_en_o` has been high for WDOG_CYC cycles, it drops and the run ends with fail. This also applies when the pulse would have ended in that same cycle. In that case no dummy write or read follows.
- R6: In the cycle after each erase pulse, exactly one write of byte 0xFF is made to the block's first byte address, whose two low bits are 00. This write comes before any read of that attempt.
- R7: Verify reads start at the dummy-write address and step by 4 bytes, one per cycle, ending at the block's last word. A word equal to 0xFFFFFFFF counts as erased.
- R8: A word that is not erased starts a new erase attempt in the next cycle. A mismatch during attempt MAX_TRY (default 100) ends the run with fail.
- R9: `retry_o` gives the number of erase attempts in the current or most recent run. It keeps its value after the run ends, until the next accepted start.
- R10: `done_o` is high for a single cycle at the end of a run. From that cycle until the next accepted start, exactly one of `pass_o` and `fail_o` is high.
- R11: `irq_block_o` is high in every cycle of a run, including every erase, write and read cycle, and low when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, sampled in S_IDLE |
| blk_mask_i | input | NBLK | Block-select mask |
| ers_en_o | output | 1 | Erase enable to the flash |
| ers_blk_o | output | NBLK | Block being erased, zero when not erasing |
| fl_wr_o | output | 1 | Flash write strobe (dummy write) |
| fl_rd_o | output | 1 | Flash read strobe |
| fl_addr_o | output | AW | Flash byte address |
| fl_wdata_o | output | 8 | Write data byte |
| fl_rdata_i | input | 32 | Read data, valid in the cycle of the read strobe |
| irq_block_o | output | 1 | Suppresses all interrupts, the non-maskable one included |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Last run verified clean |
| fail_o | output | 1 | Last run failed (retry limit or watchdog) |
| sel_err_o | output | 1 | One-cycle pulse on a refused start |
| retry_o | output | 7 | Erase attempts in the current or last run |

## Verification
Two pairs of events can land in the same cycle.

The first pair is the end of the erase pulse and the watchdog trip. A second instance, built with ERASE_CYC equal to WDOG_CYC, makes the two coincide. The result counts as correct only if the pulse lasts WDOG_CYC cycles, the run ends with fail, no dummy write appears and the attempt count stays at one.

The second pair is a mismatch and the end of the scan. The flash model plants a dirty word at the last word of the block. In that cycle the re-erase must win over the clean finish, and the bench confirms this from the arithmetic totals of erase cycles, writes and reads.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ERASE,
        S_DUMMY,
        S_VERIFY,
        S_FINISH
    } seq_state_t;

    localparam logic [7:0]  DUMMY_BYTE = 8'hFF;
    localparam logic [31:0] BLANK_WORD = 32'hFFFF_FFFF;

endpackage

// File: rtl/erase_pulse_timer.sv
module erase_pulse_timer #(
    parameter int unsigned ERASE_CYC = 200,
    parameter int unsigned WDOG_CYC  = 4000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic pulse_end_o,
    output logic wd_trip_o
);
    localparam int unsigned MAXC = (ERASE_CYC > WDOG_CYC) ? ERASE_CYC : WDOG_CYC;
    localparam int unsigned CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni)    cnt_q <= '0;
        else if (run_i) cnt_q <= cnt_q + CW'(1);
        else            cnt_q <= '0;
    end

    assign pulse_end_o = run_i && (cnt_q == CW'(ERASE_CYC - 1));
    assign wd_trip_o   = run_i && (cnt_q == CW'(WDOG_CYC - 1));

    assert_wd_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> (cnt_q < CW'(WDOG_CYC)));

endmodule

// File: rtl/verify_scanner.sv
module verify_scanner #(
    parameter int unsigned           NBLK      = 4,
    parameter int unsigned           AW        = 16,
    parameter int unsigned           WW        = 8,
    parameter logic [NBLK*WW-1:0]    BLK_WORDS = {8'd16, 8'd4, 8'd8, 8'd4}
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NBLK-1:0] sel_i,
    input  logic            load_i,
    input  logic            adv_i,
    input  logic            active_i,
    output logic [AW-1:0]   base_o,
    output logic [AW-1:0]   addr_o,
    output logic            last_o
);
    logic [AW-1:0] acc;
    logic [WW-1:0] len;
    logic [WW-1:0] idx_q;

    always_comb begin
        acc    = '0;
        base_o = '0;
        len    = '0;
        for (int b = 0; b < NBLK; b++) begin
            if (sel_i[b]) begin
                base_o = acc;
                len    = BLK_WORDS[b*WW +: WW];
            end
            acc = acc + AW'({BLK_WORDS[b*WW +: WW], 2'b00});
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni)     idx_q <= '0;
        else if (load_i) idx_q <= '0;
        else if (adv_i)  idx_q <= idx_q + WW'(1);
    end

    assign addr_o = base_o + AW'({idx_q, 2'b00});
    assign last_o = (idx_q == len - WW'(1));

    assert_stay_in_block_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        active_i |-> (idx_q <= len - WW'(1)));

endmodule

// File: rtl/blk_erase_seq.sv
module blk_erase_seq
    import erase_seq_pkg::*;
#(
    parameter int unsigned        NBLK      = 4,
    parameter int unsigned        AW        = 16,
    parameter int unsigned        WW        = 8,
    parameter logic [NBLK*WW-1:0] BLK_WORDS = {8'd16, 8'd4, 8'd8, 8'd4},
    parameter int unsigned        ERASE_CYC = 200,
    parameter int unsigned        WDOG_CYC  = 4000,
    parameter int unsigned        MAX_TRY   = 100
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            start_i,
    input  logic [NBLK-1:0] blk_mask_i,
    output logic            ers_en_o,
    output logic [NBLK-1:0] ers_blk_o,
    output logic            fl_wr_o,
    output logic            fl_rd_o,
    output logic [AW-1:0]   fl_addr_o,
    output logic [7:0]      fl_wdata_o,
    input  logic [31:0]     fl_rdata_i,
    output logic            irq_block_o,
    output logic            busy_o,
    output logic            done_o,
    output logic            pass_o,
    output logic            fail_o,
    output logic            sel_err_o,
    output logic [6:0]      retry_o
);
    seq_state_t      st_q, st_nx;
    logic [NBLK-1:0] sel_q;
    logic [6:0]      try_q;
    logic            pass_q, fail_q, selerr_q;

    logic            mask_ok, accept, word_ok, last_word;
    logic            pulse_end, wd_trip, scan_adv;
    logic            fin_pass, fin_fail;
    logic [AW-1:0]   base_addr, scan_addr;

    assign mask_ok = (blk_mask_i != '0) && ((blk_mask_i & (blk_mask_i - NBLK'(1))) == '0);
    assign accept  = (st_q == S_IDLE) && start_i && mask_ok;
    assign word_ok = (fl_rdata_i == BLANK_WORD);

    erase_pulse_timer #(.ERASE_CYC(ERASE_CYC), .WDOG_CYC(WDOG_CYC)) u_timer (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .run_i       (st_q == S_ERASE),
        .pulse_end_o (pulse_end),
        .wd_trip_o   (wd_trip)
    );

    assign scan_adv = (st_q == S_VERIFY) && word_ok && !last_word;

    verify_scanner #(.NBLK(NBLK), .AW(AW), .WW(WW), .BLK_WORDS(BLK_WORDS)) u_scan (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sel_i    (sel_q),
        .load_i   (st_q == S_DUMMY),
        .adv_i    (scan_adv),
        .active_i (st_q == S_VERIFY),
        .base_o   (base_addr),
        .addr_o   (scan_addr),
        .last_o   (last_word)
    );

    // next state and end-of-run verdicts
    always_comb begin
        st_nx    = st_q;
        fin_pass = 1'b0;
        fin_fail = 1'b0;
        unique case (st_q)
            S_IDLE:   if (accept) st_nx = S_ERASE;            // T_ACCEPT
            S_ERASE: begin
                if (wd_trip) begin                             // T_WD_TRIP wins
                    st_nx    = S_FINISH;
                    fin_fail = 1'b1;
                end else if (pulse_end) begin
                    st_nx = S_DUMMY;                           // T_PULSE_END
                end
            end
            S_DUMMY:  st_nx = S_VERIFY;                        // T_SCAN
            S_VERIFY: begin
                if (!word_ok) begin
                    if (try_q >= 7'(MAX_TRY)) begin            // T_GIVE_UP
                        st_nx    = S_FINISH;
                        fin_fail = 1'b1;
                    end else begin
                        st_nx = S_ERASE;                       // T_REERASE
                    end
                end else if (last_word) begin                  // T_CLEAN
                    st_nx    = S_FINISH;
                    fin_pass = 1'b1;
                end
            end
            S_FINISH: st_nx = S_IDLE;                          // T_RETURN
            default:  st_nx = S_IDLE;
        endcase
    end

    // state register and run data
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q     <= S_IDLE;
            sel_q    <= '0;
            try_q    <= '0;
            pass_q   <= 1'b0;
            fail_q   <= 1'b0;
            selerr_q <= 1'b0;
        end else begin
            st_q     <= st_nx;
            selerr_q <= (st_q == S_IDLE) && start_i && !mask_ok;
            if (accept) begin
                sel_q  <= blk_mask_i;
                try_q  <= 7'd1;
                pass_q <= 1'b0;
                fail_q <= 1'b0;
            end else begin
                if (st_q == S_VERIFY && st_nx == S_ERASE) try_q <= try_q + 7'd1;
                if (fin_pass) pass_q <= 1'b1;
                if (fin_fail) fail_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        ers_en_o   = 1'b0;
        fl_wr_o    = 1'b0;
        fl_rd_o    = 1'b0;
        fl_addr_o  = '0;
        fl_wdata_o = '0;
        done_o     = 1'b0;
        unique case (st_q)
            S_IDLE:   ;
            S_ERASE:  ers_en_o = 1'b1;
            S_DUMMY: begin
                fl_wr_o    = 1'b1;
                fl_addr_o  = base_addr;
                fl_wdata_o = DUMMY_BYTE;
            end
            S_VERIFY: begin
                fl_rd_o   = 1'b1;
                fl_addr_o = scan_addr;
            end
            S_FINISH: done_o = 1'b1;
            default:  ;
        endcase
        ers_blk_o   = ers_en_o ? sel_q : '0;
        busy_o      = (st_q != S_IDLE);
        irq_block_o = busy_o;
        pass_o      = pass_q;
        fail_o      = fail_q;
        sel_err_o   = selerr_q;
        retry_o     = try_q;
    end

    assert_reject_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((st_q == S_IDLE) && start_i && !mask_ok) |=> (sel_err_o && !busy_o));
    assert_single_block_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ers_en_o |-> ($countones(ers_blk_o) == 1));
    assert_block_steady_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ers_en_o |=> (!ers_en_o || $stable(ers_blk_o)));
    assert_write_before_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fl_rd_o) |-> $past(fl_wr_o));
    assert_retry_cap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        retry_o <= 7'(MAX_TRY));
    assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);
    assert_verdict_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (pass_o != fail_o));
    assert_irq_cover_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ers_en_o || fl_wr_o || fl_rd_o) |-> irq_block_o);

endmodule

// File: tb/tb_blk_erase_seq.sv
module tb_blk_erase_seq;
    localparam int NB = 4;
    localparam int EC = 5;
    localparam int WD = 40;
    localparam int MT = 100;
    localparam logic [NB*8-1:0] BW = {8'd16, 8'd4, 8'd8, 8'd4};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          start = 1'b0;
    logic [NB-1:0] mask  = '0;
    logic          ers, wr, rd, irq, busy, done, pass, fail, serr;
    logic [NB-1:0] eblk;
    logic [15:0]   addr;
    logic [7:0]    wdata;
    logic [31:0]   rdata;
    logic [6:0]    retry;

    blk_erase_seq #(.NBLK(NB), .AW(16), .WW(8), .BLK_WORDS(BW), .ERASE_CYC(EC),
                    .WDOG_CYC(WD), .MAX_TRY(MT)) dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .blk_mask_i(mask),
        .ers_en_o(ers), .ers_blk_o(eblk), .fl_wr_o(wr), .fl_rd_o(rd),
        .fl_addr_o(addr), .fl_wdata_o(wdata), .fl_rdata_i(rdata),
        .irq_block_o(irq), .busy_o(busy), .done_o(done), .pass_o(pass),
        .fail_o(fail), .sel_err_o(serr), .retry_o(retry));

    // watchdog-coincidence instance: pulse end and trip on the same cycle
    logic          w_start = 1'b0;
    logic          w_ers, w_wr, w_rd, w_irq, w_busy, w_done, w_pass, w_fail, w_serr;
    logic [NB-1:0] w_eblk;
    logic [15:0]   w_addr;
    logic [7:0]    w_wdata;
    logic [6:0]    w_retry;

    blk_erase_seq #(.NBLK(NB), .AW(16), .WW(8), .BLK_WORDS(BW), .ERASE_CYC(6),
                    .WDOG_CYC(6), .MAX_TRY(MT)) dut_wd (
        .clk_i(clk), .rst_ni(rst_n), .start_i(w_start), .blk_mask_i(4'b0010),
        .ers_en_o(w_ers), .ers_blk_o(w_eblk), .fl_wr_o(w_wr), .fl_rd_o(w_rd),
        .fl_addr_o(w_addr), .fl_wdata_o(w_wdata), .fl_rdata_i(32'hFFFF_FFFF),
        .irq_block_o(w_irq), .busy_o(w_busy), .done_o(w_done), .pass_o(w_pass),
        .fail_o(w_fail), .sel_err_o(w_serr), .retry_o(w_retry));

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int words_of(input int b);
        return int'(BW[b*8 +: 8]);
    endfunction

    function automatic int base_of(input int b);
        int s = 0;
        for (int k = 0; k < b; k++) s += 4 * words_of(k);
        return s;
    endfunction

    // flash model
    int pulses [NB];
    int need   [NB];
    int badw   [NB];

    always @* begin
        rdata = 32'hFFFF_FFFF;
        for (int b = 0; b < NB; b++) begin
            if (int'(addr) >= base_of(b) && int'(addr) < base_of(b) + 4 * words_of(b))
                if ((int'(addr) - base_of(b)) / 4 == badw[b] && pulses[b] < need[b])
                    rdata = 32'hFFFF_FF7F;
        end
    end

    // monitor
    int n_ers = 0, n_wr = 0, n_rd = 0, rd_idx = 0;
    int cur_blk = 0, cur_base = 0;
    logic [NB-1:0] cur_mask = '0;
    bit seen_ers = 0, prev_ers = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ers) begin
                n_ers++;
                seen_ers = 1;
                chk(eblk == cur_mask, "R2", "erase block", eblk, cur_mask);
            end
            if (wr) begin
                n_wr++;
                chk(seen_ers, "R3", "write before erase", 0, 1);
                chk(int'(addr) == cur_base && addr[1:0] == 2'b00, "R6", "dummy addr", addr, cur_base);
                chk(wdata == 8'hFF, "R6", "dummy data", wdata, 8'hFF);
                rd_idx = 0;
            end
            if (rd) begin
                n_rd++;
                chk(int'(addr) == cur_base + 4 * rd_idx, "R7", "read addr", addr, cur_base + 4 * rd_idx);
                rd_idx++;
            end
            if (ers || wr || rd) chk(irq, "R11", "irq block in run", irq, 1);
            if (prev_ers && !ers) pulses[cur_blk]++;
            prev_ers = ers;
        end
    end

    task automatic run_one(input int b, input int nd, input int bw, input bit poke);
        int t = 0;
        int tries, exp_rd;
        bit exp_pass;
        n_ers = 0; n_wr = 0; n_rd = 0; rd_idx = 0; seen_ers = 0;
        cur_blk = b; cur_mask = NB'(1) << b; cur_base = base_of(b);
        need[b] = nd; badw[b] = bw; pulses[b] = 0;
        @(negedge clk); start = 1'b1; mask = cur_mask;
        @(negedge clk); start = 1'b0;
        chk(ers, "R3", "erase first cycle", ers, 1);
        if (poke) begin
            @(negedge clk); start = 1'b1; mask = 4'b1000 >> b % 2;
            @(negedge clk); start = 1'b0;
        end
        while (!done && t < 20000) begin @(negedge clk); t++; end
        chk(done, "R10", "done reached", done, 1);
        exp_pass = (nd <= MT);
        tries    = exp_pass ? nd : MT;
        exp_rd   = exp_pass ? (nd - 1) * (bw + 1) + words_of(b) : MT * (bw + 1);
        chk(pass == exp_pass && fail == !exp_pass, "R10", "verdict pass", pass, exp_pass);
        chk(int'(retry) == tries, "R9", "attempts", retry, tries);
        chk(n_ers == tries * EC, "R4", "erase cycles", n_ers, tries * EC);
        chk(n_wr == tries, "R6", "dummy writes", n_wr, tries);
        chk(n_rd == exp_rd, "R8", "reads", n_rd, exp_rd);
        @(negedge clk);
        chk(!done, "R10", "done one cycle", done, 0);
        chk(pass == exp_pass && fail == !exp_pass, "R10", "verdict held", fail, !exp_pass);
        chk(int'(retry) == tries, "R9", "attempts held", retry, tries);
        chk(!irq && !busy, "R11", "irq low idle", irq, 0);
    endtask

    initial begin
        int t;
        for (int b = 0; b < NB; b++) begin pulses[b] = 0; need[b] = 0; badw[b] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !pass && !fail && !irq && !ers && !serr, "R10", "reset idle", busy, 0);
        chk(retry == 7'd0, "R9", "reset retry", retry, 0);

        // refused masks (R1), all non-one-hot patterns
        for (int m = 0; m < 16; m++) begin
            if ($countones(m) != 1) begin
                n_ers = 0; n_wr = 0; n_rd = 0;
                @(negedge clk); start = 1'b1; mask = NB'(m);
                @(negedge clk); start = 1'b0;
                chk(serr && !busy, "R1", "refused start", {serr, busy}, 2);
                @(negedge clk);
                chk(!serr && !busy, "R1", "error one cycle", serr, 0);
                chk(n_ers + n_wr + n_rd == 0, "R1", "no flash access", n_ers + n_wr + n_rd, 0);
            end
        end

        // sweep: every block, retry count, dirty word at first and last position
        for (int b = 0; b < NB; b++)
            for (int nd = 1; nd <= 3; nd++) begin
                run_one(b, nd, 0, 1'b0);
                run_one(b, nd, words_of(b) - 1, 1'b0);   // mismatch on last word (R8)
            end

        // start while busy is ignored (R2)
        run_one(1, 2, 3, 1'b1);
        // retry limit (R8)
        run_one(3, MT + 1, 2, 1'b0);

        // watchdog coincides with pulse end (R5)
        begin
            int we = 0, wwr = 0;
            @(negedge clk); w_start = 1'b1;
            @(negedge clk); w_start = 1'b0;
            t = 0;
            while (!w_done && t < 1000) begin
                if (w_ers) we++;
                if (w_wr || w_rd) wwr++;
                @(negedge clk); t++;
            end
            chk(w_done, "R5", "wd done", w_done, 1);
            chk(we == 6, "R5", "wd pulse length", we, 6);
            chk(wwr == 0, "R5", "no verify after trip", wwr, 0);
            chk(w_fail && !w_pass, "R5", "wd fail", w_fail, 1);
            chk(w_retry == 7'd1, "R5", "wd attempts", w_retry, 1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: actual 0 expected 1 (run timed out)");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule